// File: doc/BRIEF.md
# UART Loop-Back Diagnostic Router

This block sits between one UART channel's core and its board-level serial and modem-control pins. In normal operation it passes the transmitter's serial output to the TX pin, brings the RX pin into the receiver, and drives the four modem-control output pins from the modem control register. The modem-status input pins are synchronized, captured into a status register, and changes are flagged for software.

When the loop-back bit of the modem control register is set, the block isolates the channel for self-test. The TX pin and all modem-control output pins are parked inactive. The serial output is fed straight back into the receiver, and each modem-control bit is cross-wired to one status input. Test bytes written by the host then return through the receiver, and the host can toggle control bits and watch the matching status bits and change flags react. A guard on the receive path keeps mode switches from being seen as start bits.

Top module: `uart_lb_router`

## Requirements
- R1: While reset is asserted, and after it is released until inputs change, `msr` reads 0 and `core_rxd` is 1.
- R2: With `mcr[4]`=0, `pin_txd` equals `core_txd`. `pin_dtr_n`, `pin_rts_n`, `pin_op1_n` and `pin_op2_n` are the inverses of `mcr[0]`, `mcr[1]`, `mcr[2]` and `mcr[3]`. `core_rxd` follows `pin_rxd` three clock edges later: two synchronizer stages and one output register.
- R3: With `mcr[4]`=1, `pin_txd` is 1 and all four modem-control output pins are 1 (inactive), whatever `mcr[3:0]` and `core_txd` are.
- R4: With `mcr[4]`=1 and the guard clear, `core_rxd` equals `core_txd` from one clock edge earlier, and `pin_rxd` has no effect.
- R5: `msr` layout: [7] carrier detect, [6] ring, [5] data-set-ready, [4] clear-to-send, [3] carrier change, [2] ring trailing edge, [1] data-set-ready change, [0] clear-to-send change. With `mcr[4]`=1, one edge after sampling, `msr[4]` holds `mcr[1]`, `msr[5]` holds `mcr[0]`, `msr[6]` holds `mcr[2]` and `msr[7]` holds `mcr[3]`. The four modem input pins have no effect.
- R6: With `mcr[4]`=0, `msr[7:4]` hold the inverses of `pin_dcd_n`, `pin_ri_n`, `pin_dsr_n` and `pin_cts_n`, three clock edges after the pin changes.
- R7: `msr[0]`, `msr[1]` and `msr[3]` are set when the registered clear-to-send, data-set-ready or carrier bit changes in either direction. They stay set until cleared.
- R8: `msr[2]` is set only when the registered ring bit goes from 1 to 0, never when it goes from 0 to 1.
- R9: A clock edge with `msr_rd`=1 clears `msr[3:0]`. A change detected at that same edge still sets its flag.
- R10: After any change of `mcr[4]`, `core_rxd` is held at 1 until the newly selected receive source has been sampled at 1. It then follows that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcr | input | 5 | Modem control: [0] DTR, [1] RTS, [2] OP1, [3] OP2, [4] loop-back |
| msr_rd | input | 1 | Status register read strobe, clears change flags |
| msr | output | 8 | Modem status register (layout in R5) |
| core_txd | input | 1 | Serial output of the transmitter |
| core_rxd | output | 1 | Serial input to the receiver |
| pin_txd | output | 1 | TX pin |
| pin_rxd | input | 1 | RX pin |
| pin_rts_n | output | 1 | Request-to-send pin, active low |
| pin_dtr_n | output | 1 | Data-terminal-ready pin, active low |
| pin_op1_n | output | 1 | User output 1 pin, active low |
| pin_op2_n | output | 1 | User output 2 pin, active low |
| pin_cts_n | input | 1 | Clear-to-send pin, active low |
| pin_dsr_n | input | 1 | Data-set-ready pin, active low |
| pin_dcd_n | input | 1 | Carrier-detect pin, active low |
| pin_ri_n | input | 1 | Ring-indicator pin, active low |

## Verification
The assertions check on every cycle that the output pins are parked during loop-back and that the status bits track the cross-wired control bits one edge later. They also check that every rising change flag comes with a change of its line, that ring flags only on a trailing edge, that flags persist without a read and drop on a read without a change, and that a falling receive edge never follows a mode switch directly. The synchronizer latency from the pins, the hold-off length of the receive guard for each mode and source level, the read-and-change collision, and the isolation of external pins during loop-back are shown only by the bench's scenarios. The bench compares every output against its reference model on each clock.

// File: rtl/uart_lb_pkg.sv
`timescale 1ns/1ps
package uart_lb_pkg;
  localparam int MCR_W    = 5;
  localparam int MCR_DTR  = 0;
  localparam int MCR_RTS  = 1;
  localparam int MCR_OP1  = 2;
  localparam int MCR_OP2  = 3;
  localparam int MCR_LOOP = 4;

  localparam int LINES    = 4;
  localparam int MSR_W    = 2 * LINES;
  localparam int RING_IDX = 2;

  // field order matches the status register upper nibble
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } modem_t;
endpackage

// File: rtl/lb_sync.sv
`timescale 1ns/1ps
module lb_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/lb_route.sv
`timescale 1ns/1ps
module lb_route
  import uart_lb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MCR_W-1:0] mcr,
  input  logic             core_txd,
  input  logic             rxd_sync,
  input  modem_t           pin_lines,
  output logic             pin_txd,
  output logic             pin_rts_n,
  output logic             pin_dtr_n,
  output logic             pin_op1_n,
  output logic             pin_op2_n,
  output logic             core_rxd,
  output modem_t           stat_src
);
  logic   loop_on;
  modem_t loop_lines;
  logic   rx_src;
  logic   mode_flip;
  logic   guard_q, guard_d;
  logic   loop_q, loop_d;
  logic   rxd_q, rxd_d;

  assign loop_on = mcr[MCR_LOOP];

  // pin side: parked at mark / inactive while looping
  assign pin_txd   = loop_on | core_txd;
  assign pin_rts_n = loop_on | ~mcr[MCR_RTS];
  assign pin_dtr_n = loop_on | ~mcr[MCR_DTR];
  assign pin_op1_n = loop_on | ~mcr[MCR_OP1];
  assign pin_op2_n = loop_on | ~mcr[MCR_OP2];

  // internal cross-wiring of control outputs onto status inputs
  always_comb begin
    loop_lines.cts = mcr[MCR_RTS];
    loop_lines.dsr = mcr[MCR_DTR];
    loop_lines.ri  = mcr[MCR_OP1];
    loop_lines.dcd = mcr[MCR_OP2];
  end

  assign stat_src = loop_on ? loop_lines : pin_lines;
  assign rx_src   = loop_on ? core_txd : rxd_sync;

  // receive guard: after a mode flip hold mark until the new source idles
  always_comb begin
    mode_flip = loop_on ^ loop_q;
    loop_d    = loop_on;
    if (mode_flip || guard_q) begin
      rxd_d   = 1'b1;
      guard_d = ~rx_src;
    end else begin
      rxd_d   = rx_src;
      guard_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q  <= 1'b0;
      guard_q <= 1'b0;
      rxd_q   <= 1'b1;
    end else begin
      loop_q  <= loop_d;
      guard_q <= guard_d;
      rxd_q   <= rxd_d;
    end
  end

  assign core_rxd = rxd_q;
endmodule

// File: rtl/lb_msr_track.sv
`timescale 1ns/1ps
module lb_msr_track
  import uart_lb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  modem_t           src,
  input  logic             rd,
  output logic [MSR_W-1:0] msr
);
  logic [LINES-1:0] src_v;
  logic [LINES-1:0] line_q, line_d;
  logic [LINES-1:0] flag_q, flag_d;
  logic [LINES-1:0] hit;

  assign src_v = src;

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      if (i == RING_IDX) begin : g_trail
        assign hit[i] = line_q[i] & ~src_v[i];
      end else begin : g_any
        assign hit[i] = line_q[i] ^ src_v[i];
      end
    end
  endgenerate

  always_comb begin
    line_d = src_v;
    flag_d = (rd ? '0 : flag_q) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      flag_q <= '0;
    end else begin
      line_q <= line_d;
      flag_q <= flag_d;
    end
  end

  assign msr = {line_q, flag_q};
endmodule

// File: rtl/uart_lb_router.sv
`timescale 1ns/1ps
module uart_lb_router
  import uart_lb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MCR_W-1:0] mcr,
  input  logic             msr_rd,
  output logic [MSR_W-1:0] msr,
  input  logic             core_txd,
  output logic             core_rxd,
  output logic             pin_txd,
  input  logic             pin_rxd,
  output logic             pin_rts_n,
  output logic             pin_dtr_n,
  output logic             pin_op1_n,
  output logic             pin_op2_n,
  input  logic             pin_cts_n,
  input  logic             pin_dsr_n,
  input  logic             pin_dcd_n,
  input  logic             pin_ri_n
);
  localparam int SYNC_W = LINES + 1;

  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] sync_out;
  modem_t            pin_lines;
  modem_t            stat_src;

  // order: rxd, dcd_n, ri_n, dsr_n, cts_n (low nibble matches modem_t)
  assign raw_in = {pin_rxd, pin_dcd_n, pin_ri_n, pin_dsr_n, pin_cts_n};

  lb_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL({SYNC_W{1'b1}})
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_in),
    .q    (sync_out)
  );

  assign pin_lines = modem_t'(~sync_out[LINES-1:0]);

  lb_route u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .mcr      (mcr),
    .core_txd (core_txd),
    .rxd_sync (sync_out[LINES]),
    .pin_lines(pin_lines),
    .pin_txd  (pin_txd),
    .pin_rts_n(pin_rts_n),
    .pin_dtr_n(pin_dtr_n),
    .pin_op1_n(pin_op1_n),
    .pin_op2_n(pin_op2_n),
    .core_rxd (core_rxd),
    .stat_src (stat_src)
  );

  lb_msr_track u_track (
    .clk  (clk),
    .rst_n(rst_n),
    .src  (stat_src),
    .rd   (msr_rd),
    .msr  (msr)
  );
endmodule

// File: rtl/uart_lb_router_chk.sv
`timescale 1ns/1ps
module uart_lb_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] mcr,
  input logic       msr_rd,
  input logic [7:0] msr,
  input logic       core_rxd,
  input logic       pin_txd,
  input logic       pin_rts_n,
  input logic       pin_dtr_n,
  input logic       pin_op1_n,
  input logic       pin_op2_n
);
  // R3
  a_r3_pins_parked: assert property (@(posedge clk) disable iff (!rst_n)
    mcr[4] |-> (pin_txd && pin_rts_n && pin_dtr_n && pin_op1_n && pin_op2_n));

  // R5
  a_r5_loop_status: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mcr[4])) |->
      (msr[7:4] == {$past(mcr[3]), $past(mcr[2]), $past(mcr[0]), $past(mcr[1])}));

  // R7
  a_r7_cts_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && msr[0] && !$past(msr[0])) |-> (msr[4] != $past(msr[4])));
  a_r7_dsr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && msr[1] && !$past(msr[1])) |-> (msr[5] != $past(msr[5])));
  a_r7_dcd_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && msr[3] && !$past(msr[3])) |-> (msr[7] != $past(msr[7])));
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(msr_rd)) |-> ((msr[3:0] & $past(msr[3:0])) == $past(msr[3:0])));

  // R8
  a_r8_ring_trailing: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && msr[2] && !$past(msr[2])) |-> ($past(msr[6]) && !msr[6]));

  // R9
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(msr_rd) && (msr[7:4] == $past(msr[7:4]))) |-> (msr[3:0] == 4'h0));

  // R10
  a_r10_no_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n) && $fell(core_rxd)) |-> ($past(mcr[4]) == $past(mcr[4], 2)));
endmodule

bind uart_lb_router uart_lb_router_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mcr      (mcr),
  .msr_rd   (msr_rd),
  .msr      (msr),
  .core_rxd (core_rxd),
  .pin_txd  (pin_txd),
  .pin_rts_n(pin_rts_n),
  .pin_dtr_n(pin_dtr_n),
  .pin_op1_n(pin_op1_n),
  .pin_op2_n(pin_op2_n)
);

// File: tb/uart_lb_router_test.sv
`timescale 1ns/1ps
module uart_lb_router_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] mcr = 5'h00;
  logic       msr_rd = 1'b0;
  logic [7:0] msr;
  logic       core_txd = 1'b1;
  logic       core_rxd;
  logic       pin_txd;
  logic       pin_rxd = 1'b1;
  logic       pin_rts_n, pin_dtr_n, pin_op1_n, pin_op2_n;
  logic       pin_cts_n = 1'b1, pin_dsr_n = 1'b1, pin_dcd_n = 1'b1, pin_ri_n = 1'b1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  uart_lb_router uut (
    .clk(clk), .rst_n(rst_n), .mcr(mcr), .msr_rd(msr_rd), .msr(msr),
    .core_txd(core_txd), .core_rxd(core_rxd), .pin_txd(pin_txd), .pin_rxd(pin_rxd),
    .pin_rts_n(pin_rts_n), .pin_dtr_n(pin_dtr_n), .pin_op1_n(pin_op1_n), .pin_op2_n(pin_op2_n),
    .pin_cts_n(pin_cts_n), .pin_dsr_n(pin_dsr_n), .pin_dcd_n(pin_dcd_n), .pin_ri_n(pin_ri_n)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit [4:0] m_s[$];          // pin samples in flight, oldest first
  bit       m_loopq, m_guard, m_rxd, m_prev_rd;
  bit [3:0] m_line, m_flag;  // {dcd, ri, dsr, cts}
  string    rx_tag;

  task automatic model_reset();
    m_s = {5'h1f, 5'h1f};
    m_loopq = 0; m_guard = 0; m_rxd = 1; m_prev_rd = 0;
    m_line = 0; m_flag = 0;
    rx_tag = "R1";
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      bit [4:0] oldest;
      bit [3:0] src, hit;
      bit       rsrc, lp;
      oldest = m_s[0];
      lp = mcr[4];
      src = lp ? {mcr[3], mcr[2], mcr[0], mcr[1]} : ~oldest[3:0];
      for (int i = 0; i < 4; i++)
        hit[i] = (i == 2) ? (m_line[i] && !src[i]) : (m_line[i] != src[i]);
      m_flag = (msr_rd ? 4'h0 : m_flag) | hit;
      m_line = src;
      m_prev_rd = msr_rd;
      rsrc = lp ? core_txd : oldest[4];
      if (lp != m_loopq || m_guard) begin
        m_rxd = 1; m_guard = !rsrc; rx_tag = "R10";
      end else begin
        m_rxd = rsrc; rx_tag = lp ? "R4" : "R2";
      end
      m_loopq = lp;
      void'(m_s.pop_front());
      m_s.push_back({pin_rxd, pin_dcd_n, pin_ri_n, pin_dsr_n, pin_cts_n});
    end
    #2;
    if (rst_n && !done) begin
      string pt, st;
      pt = mcr[4] ? "R3" : "R2";
      st = mcr[4] ? "R5" : "R6";
      chk(pt, "pin_txd", pin_txd, mcr[4] ? 1 : core_txd);
      chk(pt, "pin_rts_n", pin_rts_n, mcr[4] ? 1 : !mcr[1]);
      chk(pt, "pin_dtr_n", pin_dtr_n, mcr[4] ? 1 : !mcr[0]);
      chk(pt, "pin_op1_n", pin_op1_n, mcr[4] ? 1 : !mcr[2]);
      chk(pt, "pin_op2_n", pin_op2_n, mcr[4] ? 1 : !mcr[3]);
      chk(rx_tag, "core_rxd", core_rxd, m_rxd);
      chk(st, "msr lines", msr[7:4], m_line);
      chk(m_prev_rd ? "R9" : "R7", "msr change flags", {msr[3], msr[1:0]}, {m_flag[3], m_flag[1:0]});
      chk("R8", "msr ring flag", msr[2], m_flag[2]);
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic read_msr();
    msr_rd = 1'b1; tick(1); msr_rd = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    tick(2);
    chk("R1", "msr in reset", msr, 0);
    chk("R1", "core_rxd in reset", core_rxd, 1);
    rst_n = 1'b1;
    tick(3);
    chk("R1", "msr after reset", msr, 0);
    chk("R1", "core_rxd after reset", core_rxd, 1);

    // normal mode: control outputs and pin pass-through (R2, R6)
    for (int v = 0; v < 16; v++) begin mcr = v[4:0]; core_txd = v[0]; tick(1); end
    pin_rxd = 0; tick(4); pin_rxd = 1; tick(4);
    pin_cts_n = 0; tick(5); pin_dsr_n = 0; tick(5); pin_dcd_n = 0; tick(5);
    read_msr(); tick(3);
    pin_cts_n = 1; pin_dsr_n = 1; pin_dcd_n = 1; tick(5);
    read_msr(); tick(2);
    // ring: leading edge gives no flag, trailing edge does (R8)
    pin_ri_n = 0; tick(6); pin_ri_n = 1; tick(6);
    read_msr(); tick(2);
    // change landing on the read edge (R9): pin edge needs three edges
    pin_cts_n = 0; tick(2); msr_rd = 1; tick(1); msr_rd = 0; tick(3);
    read_msr(); tick(2);

    // enter loop with both receive sources low (R10)
    pin_cts_n = 1; pin_rxd = 0; core_txd = 0; tick(4);
    mcr = 5'h10; tick(6);
    core_txd = 1; tick(3);
    for (int b = 0; b < 10; b++) begin core_txd = b[0] ^ b[2]; tick(2); end
    core_txd = 1;
    // loop: external pins ignored, cross-wiring (R4, R5)
    for (int v = 0; v < 16; v++) begin
      mcr = {1'b1, v[3:0]};
      pin_rxd = v[1]; pin_cts_n = v[0]; pin_dsr_n = v[2]; pin_dcd_n = v[3]; pin_ri_n = v[1];
      tick(2);
      if (v[2]) read_msr();
    end
    // leave loop while RX pin low (R10)
    pin_rxd = 0; core_txd = 1; tick(3);
    mcr = 5'h03; tick(6);
    pin_rxd = 1; tick(6);

    // mixed stress
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom;
      if (r[4:0] == 0) mcr[4] = ~mcr[4];
      if (r[7:5] == 0) mcr[3:0] = r[11:8];
      core_txd = r[12] | r[13];
      if (r[16:14] == 0) pin_rxd = ~pin_rxd;
      if (r[19:17] == 0) {pin_cts_n, pin_dsr_n, pin_dcd_n, pin_ri_n} = r[23:20];
      msr_rd = (r[27:24] == 0);
      tick(1);
    end
    msr_rd = 0;
    tick(4);
    finish_run();
  end
endmodule